// File: doc/BRIEF.md
# Dual-Target Shadow Register Update Scheduler

This block drives two identical sound chips, called left and right, that share one write path. It holds two banks of 25 eight-bit chip registers. Each bank keeps a main copy, which the host writes at any time, and a shadow copy, which records the last value sent to the chip. When an update is requested, the block walks all registers in a fixed order. It emits a write command only for a register whose main value differs from its shadow value, and the shadow takes the new value when the command is produced. When both chips would receive the same change, one command addressed to both chips replaces two commands.

Commands leave through a valid/ready stream towards a serializer. A command is offered by raising `cmd_valid`, and its target, address and data stay fixed until a cycle in which `cmd_ready` is also high. While `cmd_ready` is low the scan holds its position, so the downstream side can slow the block down by any amount without losing a command. Three other operations exist. A forced refresh rewrites every register in two passes, first with the test bit of each voice control register set, then with it cleared. An init operation sends one command that holds both chips in reset. An engine-disable input blocks normal updates.

Top module: `dual_shadow_sched`

## Requirements
- R1: An update scan issues a command for a register of a chip only if that chip's main value differs from its shadow value, and the shadow is set to the main value when the command is issued. A second update with no host writes in between issues no command.
- R2: When the left and right main values of a register are equal and the left and right shadow values are also equal, a changed register gives a single command with target both (2'b11). Otherwise, a changed left register gives a left command (2'b01), followed by a right command (2'b10) if the right register changed. Target bit 0 selects left and bit 1 selects right.
- R3: The scan visits register addresses in this order: 0,1,2,3,5,6, then 7,8,9,10,12,13, then 14,15,16,17,19,20, then the voice control registers 4,11,18, then 21,22,23,24.
- R4: A scan command carries `cmd_addr` = {3'b111, 5-bit register address}, so bit 5 high releases the chip reset, and `cmd_data` = the main value.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_target`, `cmd_addr` and `cmd_data` hold their values. A command counts as transferred in a cycle with both high.
- R6: A refresh sets every shadow value to its main value plus one (modulo 256) and sets bit 3 of the main value of the six voice control registers (addresses 4, 11, 18 in both banks). It then runs a scan, clears that bit 3 again, and runs a second scan.
- R7: An init issues exactly one command with target both, address byte 0x00 and data 0x00. It also sets the shadow of register 0 of both banks to 0.
- R8: While `engine_off` is high, `update_req` is ignored and is not latched. A refresh still runs.
- R9: `busy` is high from the cycle after a request is accepted until the operation ends. `done` is high for exactly one cycle after the last register or the init command has been handled. `cmd_valid` is low whenever `busy` is low.
- R10: In idle, requests are served with init first, then refresh, then update. An `update_req` that arrives while the block is busy is latched and starts a new scan directly after the current `done`. Init and refresh requests that arrive while the block is busy are ignored.
- R11: After reset, all main and shadow values are 0, and `cmd_valid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe for a main value |
| host_sel_right | input | 1 | Bank select for host write: 0 left, 1 right |
| host_addr | input | 5 | Register address of host write (0 to 24) |
| host_data | input | 8 | Value for host write |
| update_req | input | 1 | Request a change-only scan |
| refresh_req | input | 1 | Request a forced two-pass refresh |
| init_req | input | 1 | Request the chip-reset command |
| engine_off | input | 1 | Suppresses update requests |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_target | output | 2 | bit0 left chip, bit1 right chip |
| cmd_addr | output | 8 | Address byte of the command |
| cmd_data | output | 8 | Data byte of the command |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Some properties are checked on every cycle. A stalled command stays stable, and every command has a nonzero target and either the released-reset address form or the exact init form. `done` lasts one cycle and falls inside `busy`, and there is no command while idle. An update under `engine_off` never starts the block, while a refresh always does. The exact command sequence can only be seen in the bench scenarios, which compare it against a model: the change-only selection, the merge-or-split decision, the control-after-oscillator order, the two refresh passes, the shadow effect of init, and the latching of a request made while busy.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'b00,
    TGT_LEFT  = 2'b01,
    TGT_RIGHT = 2'b10,
    TGT_BOTH  = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_WAIT,
    ST_DONE
  } st_e;
endpackage

// File: rtl/dss_order.sv
// Maps a scan step to a register address: oscillator/envelope registers of
// every voice first, then the voice control registers, then the tail group.
module dss_order #(
  parameter int NUM_VOICES = 3,
  parameter int VOICE_REGS = 7,
  parameter int CTRL_OFS   = 4,
  parameter int ADDR_W     = 5,
  parameter int STEP_W     = 5
) (
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] addr
);
  localparam int OSC_PER   = VOICE_REGS - 1;
  localparam int OSC_STEPS = NUM_VOICES * OSC_PER;
  localparam int CTRL_END  = OSC_STEPS + NUM_VOICES;

  int s, k, a;

  always_comb begin
    s = int'(step);
    k = 0;
    a = 0;
    if (s < OSC_STEPS) begin
      k = s % OSC_PER;
      a = (s / OSC_PER) * VOICE_REGS + ((k < CTRL_OFS) ? k : k + 1);
    end else if (s < CTRL_END) begin
      a = (s - OSC_STEPS) * VOICE_REGS + CTRL_OFS;
    end else begin
      a = s;
    end
    addr = ADDR_W'(a);
  end
endmodule

// File: rtl/dss_bank.sv
// One chip's register bank: main copy (host side) and shadow copy (chip side).
module dss_bank #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int NUM_REGS   = 25,
  parameter int NUM_VOICES = 3,
  parameter int VOICE_REGS = 7,
  parameter int CTRL_OFS   = 4,
  parameter int TEST_BIT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              sh_we,
  input  logic              force_all,
  input  logic              clr_test,
  input  logic              init_zero,
  output logic [DATA_W-1:0] rd_main,
  output logic [DATA_W-1:0] rd_shadow
);
  logic [DATA_W-1:0] main_q   [NUM_REGS];
  logic [DATA_W-1:0] shadow_q [NUM_REGS];

  function automatic logic is_ctrl(int i);
    return (i < NUM_VOICES * VOICE_REGS) && ((i % VOICE_REGS) == CTRL_OFS);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        main_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (force_all) shadow_q[i] <= main_q[i] + DATA_W'(1);
        if (sh_we && rd_addr == ADDR_W'(i)) shadow_q[i] <= main_q[i];
        if (init_zero && i == 0) shadow_q[i] <= '0;
        if (is_ctrl(i)) begin
          if (force_all) main_q[i][TEST_BIT] <= 1'b1;
          if (clr_test)  main_q[i][TEST_BIT] <= 1'b0;
        end
        if (host_we && host_addr == ADDR_W'(i)) main_q[i] <= host_data;
      end
    end
  end

  always_comb begin
    rd_main   = '0;
    rd_shadow = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) begin
        rd_main   = main_q[i];
        rd_shadow = shadow_q[i];
      end
    end
  end
endmodule

// File: rtl/dual_shadow_sched.sv
module dual_shadow_sched
  import dss_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int CMD_ADDR_W = 8,
  parameter int NUM_VOICES = 3,
  parameter int VOICE_REGS = 7,
  parameter int CTRL_OFS   = 4,
  parameter int TAIL_REGS  = 4,
  parameter int TEST_BIT   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic                  host_sel_right,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [DATA_W-1:0]     host_data,
  input  logic                  update_req,
  input  logic                  refresh_req,
  input  logic                  init_req,
  input  logic                  engine_off,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [1:0]            cmd_target,
  output logic [CMD_ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0]     cmd_data,
  output logic                  busy,
  output logic                  done
);
  localparam int NUM_REGS = NUM_VOICES * VOICE_REGS + TAIL_REGS;
  localparam int STEP_W   = $clog2(NUM_REGS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_REGS - 1);
  localparam int HI_W     = CMD_ADDR_W - ADDR_W;

  st_e               state;
  logic [STEP_W-1:0] step;
  logic              sub, nxt_sub1, is_init, refresh_p1, pend;
  tgt_e              tgt_q;
  logic [ADDR_W-1:0] scan_addr;
  logic [DATA_W-1:0] rd_main   [2];
  logic [DATA_W-1:0] rd_shadow [2];
  logic [1:0]        sh_we;

  logic issue, go_sub1, step_adv, req_ok, start_init, start_ref, start_upd;
  logic chg_l, chg_r, merge, pass_end, force_all, clr_test, go_again;
  tgt_e iss_tgt;

  dss_order #(
    .NUM_VOICES(NUM_VOICES), .VOICE_REGS(VOICE_REGS), .CTRL_OFS(CTRL_OFS),
    .ADDR_W(ADDR_W), .STEP_W(STEP_W)
  ) u_order (
    .step(step), .addr(scan_addr)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    dss_bank #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
      .NUM_VOICES(NUM_VOICES), .VOICE_REGS(VOICE_REGS),
      .CTRL_OFS(CTRL_OFS), .TEST_BIT(TEST_BIT)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we && (host_sel_right == 1'(b))),
      .host_addr(host_addr), .host_data(host_data),
      .rd_addr(scan_addr), .sh_we(sh_we[b]),
      .force_all(force_all), .clr_test(clr_test), .init_zero(start_init),
      .rd_main(rd_main[b]), .rd_shadow(rd_shadow[b])
    );
  end

  always_comb begin
    chg_l   = rd_main[0] != rd_shadow[0];
    chg_r   = rd_main[1] != rd_shadow[1];
    merge   = (rd_main[0] == rd_main[1]) && (rd_shadow[0] == rd_shadow[1]);
    issue   = 1'b0;
    go_sub1 = 1'b0;
    iss_tgt = TGT_NONE;
    if (state == ST_SCAN) begin
      if (!sub) begin
        if (merge) begin
          issue   = chg_l;
          iss_tgt = TGT_BOTH;
        end else begin
          go_sub1 = 1'b1;
          issue   = chg_l;
          iss_tgt = TGT_LEFT;
        end
      end else begin
        issue   = chg_r;
        iss_tgt = TGT_RIGHT;
      end
    end
    step_adv = (state == ST_SCAN && !issue && !go_sub1) ||
               (state == ST_WAIT && cmd_ready && !is_init && !nxt_sub1);
    pass_end   = step_adv && (step == LAST_STEP);
    clr_test   = pass_end && refresh_p1;
    req_ok     = update_req && !engine_off;
    start_init = (state == ST_IDLE) && init_req;
    start_ref  = (state == ST_IDLE) && !init_req && refresh_req;
    start_upd  = (state == ST_IDLE) && !init_req && !refresh_req && req_ok;
    force_all  = start_ref;
    go_again   = pend || req_ok;
    sh_we[0]   = issue && iss_tgt[0];
    sh_we[1]   = issue && iss_tgt[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      step       <= '0;
      sub        <= 1'b0;
      nxt_sub1   <= 1'b0;
      is_init    <= 1'b0;
      refresh_p1 <= 1'b0;
      pend       <= 1'b0;
      cmd_valid  <= 1'b0;
      tgt_q      <= TGT_NONE;
      cmd_addr   <= '0;
      cmd_data   <= '0;
    end else begin
      if (state != ST_IDLE && state != ST_DONE && req_ok) pend <= 1'b1;
      if (issue) begin
        cmd_valid <= 1'b1;
        tgt_q     <= iss_tgt;
        cmd_addr  <= {{HI_W{1'b1}}, scan_addr};
        cmd_data  <= (iss_tgt == TGT_RIGHT) ? rd_main[1] : rd_main[0];
        nxt_sub1  <= go_sub1;
        state     <= ST_WAIT;
      end else if (state == ST_SCAN && go_sub1) begin
        sub <= 1'b1;
      end
      if (state == ST_WAIT && cmd_ready) begin
        cmd_valid <= 1'b0;
        if (is_init) begin
          is_init <= 1'b0;
          state   <= ST_DONE;
        end else if (nxt_sub1) begin
          sub   <= 1'b1;
          state <= ST_SCAN;
        end
      end
      if (step_adv) begin
        sub <= 1'b0;
        if (step != LAST_STEP) begin
          step  <= step + STEP_W'(1);
          state <= ST_SCAN;
        end else if (refresh_p1) begin
          refresh_p1 <= 1'b0;
          step       <= '0;
          state      <= ST_SCAN;
        end else begin
          state <= ST_DONE;
        end
      end
      case (state)
        ST_IDLE: begin
          step <= '0;
          sub  <= 1'b0;
          if (start_init) begin
            is_init   <= 1'b1;
            cmd_valid <= 1'b1;
            tgt_q     <= TGT_BOTH;
            cmd_addr  <= '0;
            cmd_data  <= '0;
            state     <= ST_WAIT;
          end else if (start_ref || start_upd) begin
            refresh_p1 <= start_ref;
            state      <= ST_SCAN;
          end
        end
        ST_DONE: begin
          step <= '0;
          sub  <= 1'b0;
          pend <= 1'b0;
          state <= go_again ? ST_SCAN : ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign cmd_target = tgt_q;
  assign busy       = state != ST_IDLE;
  assign done       = state == ST_DONE;
endmodule

// File: rtl/dss_checks.sv
module dss_checks #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int CMD_ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [1:0]            cmd_target,
  input logic [CMD_ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0]     cmd_data,
  input logic                  busy,
  input logic                  done,
  input logic                  update_req,
  input logic                  refresh_req,
  input logic                  init_req,
  input logic                  engine_off
);
  p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_target) &&
                                   $stable(cmd_addr) && $stable(cmd_data)));

  p_cmd_format_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((&cmd_addr[CMD_ADDR_W-1:ADDR_W]) ||
                   (cmd_addr == '0 && cmd_data == '0 && cmd_target == 2'b11)));

  p_target_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_target != 2'b00));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_engine_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && engine_off && update_req && !refresh_req && !init_req) |=> !busy);

  p_refresh_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && refresh_req) |=> busy);
endmodule

bind dual_shadow_sched dss_checks #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMD_ADDR_W(CMD_ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_target(cmd_target), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
  .busy(busy), .done(done), .update_req(update_req),
  .refresh_req(refresh_req), .init_req(init_req), .engine_off(engine_off)
);

// File: tb/dual_shadow_sched_test.sv
`timescale 1ns/1ps
module dual_shadow_sched_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0, host_sel_right = 1'b0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_data = '0;
  logic       update_req = 1'b0, refresh_req = 1'b0, init_req = 1'b0, engine_off = 1'b0;
  logic       cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_target;
  logic [7:0] cmd_addr, cmd_data;
  logic       busy, done;

  dual_shadow_sched uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel_right(host_sel_right),
    .host_addr(host_addr), .host_data(host_data), .update_req(update_req),
    .refresh_req(refresh_req), .init_req(init_req), .engine_off(engine_off),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_target(cmd_target),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done)
  );

  always #4 clk = ~clk;

  localparam int ORDER [25] = '{0,1,2,3,5,6, 7,8,9,10,12,13, 14,15,16,17,19,20,
                                4,11,18, 21,22,23,24};
  // {group end, write right, write left, addr[4:0], left value, right value}
  localparam int NVEC = 11;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 2'b11, 5'd4,  8'h41, 8'h41},
    {1'b0, 2'b11, 5'd0,  8'h12, 8'h12},
    {1'b0, 2'b11, 5'd24, 8'h0F, 8'h0F},
    {1'b1, 2'b01, 5'd11, 8'h21, 8'h00},
    {1'b0, 2'b11, 5'd2,  8'h33, 8'h44},
    {1'b0, 2'b10, 5'd18, 8'h00, 8'h81},
    {1'b1, 2'b11, 5'd21, 8'h99, 8'h99},
    {1'b0, 2'b01, 5'd0,  8'h13, 8'h00},
    {1'b0, 2'b11, 5'd13, 8'h77, 8'h77},
    {1'b0, 2'b10, 5'd7,  8'h00, 8'h05},
    {1'b1, 2'b11, 5'd2,  8'h33, 8'h33}
  };

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  int mdl_m [2][25];
  int mdl_s [2][25];
  int exp_t [256], exp_a [256], exp_d [256], n_exp = 0;
  int cap_t [256], cap_a [256], cap_d [256], n_cap = 0;
  logic rdy_low = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    cmd_ready = rdy_low ? 1'b0 : ((cyc % 3) != 2);
    if (cmd_valid && cmd_ready && n_cap < 256) begin
      cap_t[n_cap] = int'(cmd_target);
      cap_a[n_cap] = int'(cmd_addr);
      cap_d[n_cap] = int'(cmd_data);
      n_cap++;
    end
    if (done) done_cnt++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic push(input int t, input int a, input int d);
    exp_t[n_exp] = t; exp_a[n_exp] = a; exp_d[n_exp] = d; n_exp++;
  endtask

  task automatic model_scan();
    for (int k = 0; k < 25; k++) begin
      int a;
      a = ORDER[k];
      if (mdl_m[0][a] == mdl_m[1][a] && mdl_s[0][a] == mdl_s[1][a]) begin
        if (mdl_m[0][a] != mdl_s[0][a]) push(3, 32'hE0 | a, mdl_m[0][a]);
        mdl_s[0][a] = mdl_m[0][a];
        mdl_s[1][a] = mdl_m[1][a];
      end else begin
        if (mdl_m[0][a] != mdl_s[0][a]) push(1, 32'hE0 | a, mdl_m[0][a]);
        mdl_s[0][a] = mdl_m[0][a];
        if (mdl_m[1][a] != mdl_s[1][a]) push(2, 32'hE0 | a, mdl_m[1][a]);
        mdl_s[1][a] = mdl_m[1][a];
      end
    end
  endtask

  task automatic host_write(input int b, input int a, input int d);
    @(negedge clk);
    host_we = 1'b1; host_sel_right = 1'(b); host_addr = 5'(a); host_data = 8'(d);
    @(negedge clk);
    host_we = 1'b0;
    mdl_m[b][a] = d;
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    while (busy && g < 20000) begin
      @(negedge clk);
      g++;
    end
    repeat (2) @(negedge clk);
  endtask

  // kind: 0 update, 1 refresh, 2 init
  task automatic run_op(input int kind);
    n_cap = 0;
    @(negedge clk);
    if (kind == 0) update_req = 1'b1;
    if (kind == 1) refresh_req = 1'b1;
    if (kind == 2) init_req = 1'b1;
    @(negedge clk);
    update_req = 1'b0; refresh_req = 1'b0; init_req = 1'b0;
    wait_idle();
  endtask

  task automatic compare(input string tag);
    check(n_cap == n_exp, {tag, " command count"}, n_cap, n_exp);
    for (int i = 0; i < n_exp && i < n_cap; i++) begin
      check(cap_t[i] == exp_t[i], {tag, " target"}, cap_t[i], exp_t[i]);
      check(cap_a[i] == exp_a[i], {tag, " address"}, cap_a[i], exp_a[i]);
      check(cap_d[i] == exp_d[i], {tag, " data"}, cap_d[i], exp_d[i]);
    end
    n_exp = 0;
  endtask

  initial begin
    int d0;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 25; i++) begin mdl_m[b][i] = 0; mdl_s[b][i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(cmd_valid == 1'b0, "R11 cmd_valid after reset", int'(cmd_valid), 0);
    check(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R11 done after reset", int'(done), 0);

    // R1 / R9: update with nothing changed
    d0 = done_cnt;
    run_op(0);
    compare("R1 empty update");
    check(done_cnt - d0 == 1, "R9 single done pulse", done_cnt - d0, 1);

    // R1 R2 R3 R4: table of host writes, one update per group
    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] e;
      e = VEC[v];
      if (e[21]) host_write(0, int'(e[20:16]), int'(e[15:8]));
      if (e[22]) host_write(1, int'(e[20:16]), int'(e[7:0]));
      if (e[23]) begin
        model_scan();
        run_op(0);
        compare("R2 R3 R4 vector group");
      end
    end

    // R1: repeated update after no change issues nothing
    model_scan();
    run_op(0);
    compare("R1 repeat update");

    // R7: init command, then reset released by next update
    push(3, 0, 0);
    mdl_s[0][0] = 0; mdl_s[1][0] = 0;
    run_op(2);
    compare("R7 init command");
    model_scan();
    run_op(0);
    compare("R7 release after init");

    // R6 R8: refresh while engine is off still runs both passes
    engine_off = 1'b1;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 25; i++) mdl_s[b][i] = (mdl_m[b][i] + 1) & 255;
    for (int b = 0; b < 2; b++)
      for (int v = 0; v < 3; v++) mdl_m[b][v*7+4] = mdl_m[b][v*7+4] | 8;
    model_scan();
    for (int b = 0; b < 2; b++)
      for (int v = 0; v < 3; v++) mdl_m[b][v*7+4] = mdl_m[b][v*7+4] & 247;
    model_scan();
    run_op(1);
    compare("R6 R8 refresh two passes");

    // R8: update ignored while engine off, not latched
    host_write(0, 22, 8'h5C);
    host_write(1, 22, 8'h5C);
    n_cap = 0;
    @(negedge clk);
    update_req = 1'b1;
    @(negedge clk);
    update_req = 1'b0;
    check(busy == 1'b0, "R8 update ignored when engine off", int'(busy), 0);
    repeat (40) @(negedge clk);
    check(n_cap == 0, "R8 no command when engine off", n_cap, 0);
    engine_off = 1'b0;
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R8 request not latched", int'(busy), 0);
    model_scan();
    run_op(0);
    compare("R8 change sent after enable");

    // R5 R10: stalled command, second update latched, init ignored while busy
    host_write(0, 1, 8'h66);
    host_write(1, 1, 8'h66);
    d0 = done_cnt;
    n_cap = 0;
    rdy_low = 1'b1;
    @(negedge clk);
    update_req = 1'b1;
    @(negedge clk);
    update_req = 1'b0;
    repeat (6) @(negedge clk);
    check(cmd_valid == 1'b1, "R5 command held under back-pressure", int'(cmd_valid), 1);
    check(cmd_addr == 8'hE1, "R5 address stable while stalled", int'(cmd_addr), 32'hE1);
    host_write(0, 23, 8'h3C);
    host_write(1, 23, 8'h3C);
    update_req = 1'b1; init_req = 1'b1;
    @(negedge clk);
    update_req = 1'b0; init_req = 1'b0;
    rdy_low = 1'b0;
    wait_idle();
    model_scan();
    model_scan();
    compare("R10 latched rescan");
    check(done_cnt - d0 == 2, "R10 two scans completed", done_cnt - d0, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule